// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block decides where a 32-bit RISC core fetches next. Each request carries the current program counter, a decoded control-flow operation, a short (16-bit) and a long (26-bit) signed offset field, a register operand and a zero-test operand. The block returns the next program counter, a flag saying whether control left the sequential path, a flag for a target whose low two bits are not zero, and a link write (enable, register index and data) that a call produces. All offsets are byte offsets, sign-extended to 32 bits before they are added. Relative targets are based on the address after the current one (PC+4).

The block resolves four ways of forming a target: an absolute address taken from the long field, the register value alone, the register value plus the short displacement, and PC+4 plus an offset. Conditional branches test the zero-test operand for zero or for non-zero. A call sends its return address PC+4 to register 31 in the same result that carries its redirect.

Requests and results move through valid/ready handshakes. A request is accepted on a rising clock edge when `in_valid` and `in_ready` are both high, and its result appears with `out_valid` one cycle later. `in_ready` is high when the result slot is empty or when its contents are being taken in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, every result port holds its value and no new request is accepted.

Top module: `npc_unit`

## Requirements
- R1: Operation code 0 (sequential) gives next PC = PC+4 with the taken flag low.
- R2: Operation code 1 (branch if zero) is taken only when the zero-test operand equals zero; the target is PC+4 plus the sign-extended short field; when not taken the next PC is PC+4.
- R3: Operation code 2 (branch if non-zero) is taken only when the zero-test operand is not zero, with the same target and fall-through as R2.
- R4: Operation code 3 (direct jump) is always taken; the target is the long field sign-extended to 32 bits, used as an absolute byte address.
- R5: Operation code 4 (register jump) is always taken; the target is the register operand.
- R6: Operation code 5 (register plus displacement) is always taken; the target is the register operand plus the sign-extended short field.
- R7: Operation code 6 (relative jump) is always taken; the target is PC+4 plus the sign-extended long field.
- R8: Operation code 7 (call) is always taken with the R7 target, and its result carries link enable high, link index 31 and link data PC+4; every other operation gives link enable low.
- R9: The misalignment flag is high exactly when the operation is taken and the target's bits 1:0 are not both zero; the next PC is still the target.
- R10: `in_ready` equals (not `out_valid`) or `out_ready`; an accepted request gives `out_valid` on the next cycle; while `out_valid` is high and `out_ready` low, all result ports stay unchanged.
- R11: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_pc | input | 32 | Current program counter |
| in_op | input | 3 | Control-flow operation code (R1 to R8) |
| in_off16 | input | 16 | Short signed offset / displacement |
| in_off26 | input | 26 | Long signed offset / absolute target |
| in_rval | input | 32 | Register operand for indirect targets |
| in_tval | input | 32 | Zero-test operand for conditional branches |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_next_pc | output | 32 | Next program counter |
| out_taken | output | 1 | Control left the sequential path |
| out_misalign | output | 1 | Taken target with nonzero low two bits |
| out_link_we | output | 1 | Link register write enable |
| out_link_idx | output | 5 | Link destination register index |
| out_link_data | output | 32 | Return address to write |

## Verification
A call whose long offset is not a multiple of four makes the link write and the misalignment report fall in the same result, together with the redirect itself. The bench sends such a call and judges that the next PC, the flag, link enable, index 31 and link data PC+4 all appear in one beat. It also stalls a call result with `out_ready` low while a second request waits, and judges that the link fields and target stay fixed and that the waiting request enters only on the edge where the stalled result leaves.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    OP_SEQ   = 3'd0,
    OP_BEQZ  = 3'd1,
    OP_BNEZ  = 3'd2,
    OP_JABS  = 3'd3,
    OP_JREG  = 3'd4,
    OP_JDISP = 3'd5,
    OP_JREL  = 3'd6,
    OP_CALL  = 3'd7
  } npc_op_e;

endpackage

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int XLEN    = 32,
  parameter int SHORT_W = 16,
  parameter int LONG_W  = 26,
  parameter int STEP    = 4
) (
  input  npc_pkg::npc_op_e  op,
  input  logic [XLEN-1:0]    pc,
  input  logic [SHORT_W-1:0] off_s,
  input  logic [LONG_W-1:0]  off_l,
  input  logic [XLEN-1:0]    rval,
  output logic [XLEN-1:0]    seq_pc,
  output logic [XLEN-1:0]    target
);
  import npc_pkg::*;

  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] sext_s, sext_l, base, offset;

  assign sext_s = {{(XLEN-SHORT_W){off_s[SHORT_W-1]}}, off_s};
  assign sext_l = {{(XLEN-LONG_W){off_l[LONG_W-1]}}, off_l};
  assign seq_pc = pc + STEP_V;

  // one shared adder: pick base and offset per operation
  always_comb begin
    base   = seq_pc;
    offset = sext_s;
    unique case (op)
      OP_SEQ:            begin base = seq_pc;        offset = '0;     end
      OP_BEQZ, OP_BNEZ:  begin base = seq_pc;        offset = sext_s; end
      OP_JABS:           begin base = '0;            offset = sext_l; end
      OP_JREG:           begin base = rval;          offset = '0;     end
      OP_JDISP:          begin base = rval;          offset = sext_s; end
      OP_JREL, OP_CALL:  begin base = seq_pc;        offset = sext_l; end
      default:           begin base = seq_pc;        offset = '0;     end
    endcase
  end

  assign target = base + offset;

endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval #(
  parameter int XLEN = 32
) (
  input  npc_pkg::npc_op_e op,
  input  logic [XLEN-1:0]   tval,
  output logic              take,
  output logic              is_call
);
  import npc_pkg::*;

  logic is_zero;
  assign is_zero = (tval == '0);

  always_comb begin
    unique case (op)
      OP_SEQ:  take = 1'b0;
      OP_BEQZ: take = is_zero;
      OP_BNEZ: take = !is_zero;
      default: take = 1'b1;
    endcase
  end

  assign is_call = (op == OP_CALL);

endmodule

// File: rtl/npc_out_slot.sv
module npc_out_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] data_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int XLEN     = 32,
  parameter int SHORT_W  = 16,
  parameter int LONG_W   = 26,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31,
  parameter int STEP     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]    in_pc,
  input  logic [2:0]         in_op,
  input  logic [SHORT_W-1:0] in_off16,
  input  logic [LONG_W-1:0]  in_off26,
  input  logic [XLEN-1:0]    in_rval,
  input  logic [XLEN-1:0]    in_tval,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]    out_next_pc,
  output logic              out_taken,
  output logic              out_misalign,
  output logic              out_link_we,
  output logic [RIDX_W-1:0]  out_link_idx,
  output logic [XLEN-1:0]    out_link_data
);
  import npc_pkg::*;

  localparam int RES_W = 2*XLEN + RIDX_W + 3;
  localparam logic [RIDX_W-1:0] LINK_IDX = RIDX_W'(LINK_REG);

  npc_op_e         op;
  logic [XLEN-1:0] seq_pc, target, next_pc;
  logic            take, is_call, misal;
  logic [RES_W-1:0] res_d, res_q;

  assign op = npc_op_e'(in_op);

  npc_target_gen #(
    .XLEN(XLEN), .SHORT_W(SHORT_W), .LONG_W(LONG_W), .STEP(STEP)
  ) u_tgt (
    .op(op), .pc(in_pc), .off_s(in_off16), .off_l(in_off26),
    .rval(in_rval), .seq_pc(seq_pc), .target(target)
  );

  npc_cond_eval #(.XLEN(XLEN)) u_cond (
    .op(op), .tval(in_tval), .take(take), .is_call(is_call)
  );

  assign next_pc = take ? target : seq_pc;
  assign misal   = take && (target[1:0] != 2'b00);

  assign res_d = {next_pc, take, misal, is_call,
                  is_call ? LINK_IDX : '0,
                  is_call ? seq_pc   : '0};

  npc_out_slot #(.W(RES_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(res_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res_q)
  );

  assign {out_next_pc, out_taken, out_misalign, out_link_we,
          out_link_idx, out_link_data} = res_q;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN     = 32,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [XLEN-1:0]   out_next_pc,
  input logic              out_taken,
  input logic              out_misalign,
  input logic              out_link_we,
  input logic [RIDX_W-1:0] out_link_idx,
  input logic [XLEN-1:0]   out_link_data
);
  // R10: a stalled result does not move
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc) &&
      $stable(out_taken) && $stable(out_misalign) && $stable(out_link_we) &&
      $stable(out_link_idx) && $stable(out_link_data));

  // R10: an accepted request yields a result next cycle
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8: a link write comes only with a redirect and to the fixed register
  a_r8_link_taken: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_link_we |-> out_taken && (out_link_idx == RIDX_W'(LINK_REG)));

  // R9: misalignment only on a taken target with nonzero low bits
  a_r9_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_misalign |-> out_taken && (out_next_pc[1:0] != 2'b00));

  // R1: a sequential result carries no link and no misalignment
  a_r1_seq_clean: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_taken |-> !out_link_we && !out_misalign);

endmodule

bind npc_unit npc_unit_chk #(
  .XLEN(XLEN), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_next_pc(out_next_pc),
  .out_taken(out_taken), .out_misalign(out_misalign),
  .out_link_we(out_link_we), .out_link_idx(out_link_idx),
  .out_link_data(out_link_data)
);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0;
  logic [2:0]  in_op = '0;
  logic [15:0] in_off16 = '0;
  logic [25:0] in_off26 = '0;
  logic [31:0] in_rval = '0;
  logic [31:0] in_tval = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_next_pc;
  logic        out_taken, out_misalign, out_link_we;
  logic [4:0]  out_link_idx;
  logic [31:0] out_link_data;

  always #5 clk = ~clk;

  npc_unit dut (.*);

  typedef struct packed {
    logic [31:0] pc;
    logic [2:0]  op;
    logic [15:0] o16;
    logic [25:0] o26;
    logic [31:0] rv;
    logic [31:0] tv;
    logic [31:0] npc;
    logic        tk;
    logic        mis;
    logic        lwe;
  } vec_t;

  localparam int NV = 15;
  // op codes: 0 seq, 1 beqz, 2 bnez, 3 abs, 4 reg, 5 reg+disp, 6 rel, 7 call
  localparam vec_t VECS [0:NV-1] = '{
    '{32'h100, 3'd0, 16'h0000, 26'h0,       32'h0,        32'h0, 32'h104,      1'b0, 1'b0, 1'b0},
    '{32'h100, 3'd1, 16'h0010, 26'h0,       32'h0,        32'h0, 32'h114,      1'b1, 1'b0, 1'b0},
    '{32'h100, 3'd1, 16'h0010, 26'h0,       32'h0,        32'h5, 32'h104,      1'b0, 1'b0, 1'b0},
    '{32'h200, 3'd1, 16'hFFF0, 26'h0,       32'h0,        32'h0, 32'h1F4,      1'b1, 1'b0, 1'b0},
    '{32'h100, 3'd2, 16'h0020, 26'h0,       32'h0,        32'h1, 32'h124,      1'b1, 1'b0, 1'b0},
    '{32'h100, 3'd2, 16'h0020, 26'h0,       32'h0,        32'h0, 32'h104,      1'b0, 1'b0, 1'b0},
    '{32'h100, 3'd3, 16'h0000, 26'h0001000, 32'h0,        32'h0, 32'h1000,     1'b1, 1'b0, 1'b0},
    '{32'h100, 3'd3, 16'h0000, 26'h2000000, 32'h0,        32'h0, 32'hFE000000, 1'b1, 1'b0, 1'b0},
    '{32'h100, 3'd4, 16'h0000, 26'h0,       32'h80000040, 32'h0, 32'h80000040, 1'b1, 1'b0, 1'b0},
    '{32'h100, 3'd5, 16'hFFFC, 26'h0,       32'h1000,     32'h0, 32'h0FFC,     1'b1, 1'b0, 1'b0},
    '{32'h400, 3'd6, 16'h0000, 26'h3FFFFF8, 32'h0,        32'h0, 32'h3FC,      1'b1, 1'b0, 1'b0},
    '{32'h400, 3'd7, 16'h0000, 26'h0000100, 32'h0,        32'h0, 32'h504,      1'b1, 1'b0, 1'b1},
    '{32'h100, 3'd4, 16'h0000, 26'h0,       32'h1002,     32'h0, 32'h1002,     1'b1, 1'b1, 1'b0},
    '{32'h100, 3'd1, 16'h0001, 26'h0,       32'h0,        32'h7, 32'h104,      1'b0, 1'b0, 1'b0},
    '{32'h400, 3'd7, 16'h0000, 26'h0000003, 32'h0,        32'h0, 32'h407,      1'b1, 1'b1, 1'b1}
  };
  localparam string TAGS [0:NV-1] = '{
    "R1", "R2", "R2", "R2", "R3", "R3", "R4", "R4",
    "R5", "R6", "R7", "R8", "R9", "R9", "R8/R9"
  };

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_pc = v.pc; in_op = v.op; in_off16 = v.o16; in_off26 = v.o26;
    in_rval = v.rv; in_tval = v.tv;
  endtask

  task automatic check_res(input string tag, input vec_t v);
    chk(tag, "out_valid", 32'(out_valid), 32'd1);
    chk(tag, "next_pc", out_next_pc, v.npc);
    chk(tag, "taken", 32'(out_taken), 32'(v.tk));
    chk(tag, "misalign", 32'(out_misalign), 32'(v.mis));
    chk(tag, "link_we", 32'(out_link_we), 32'(v.lwe));
    if (v.lwe) begin
      chk(tag, "link_idx", 32'(out_link_idx), 32'd31);
      chk(tag, "link_data", out_link_data, v.pc + 32'd4);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    // R11: reset state
    repeat (2) @(negedge clk);
    chk("R11", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R11", "in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R11", "in_ready after reset", 32'(in_ready), 32'd1);

    // vector table walk, one request per two cycles
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      in_valid  = 1'b1;
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_res(TAGS[i], VECS[i]);
      @(negedge clk);
      chk(TAGS[i], "drained", 32'(out_valid), 32'd0);
    end

    // R10 / R8: stall a call result while another request waits
    drive(VECS[11]);
    in_valid  = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    drive(VECS[1]);
    chk("R10", "in_ready while stalled", 32'(in_ready), 32'd0);
    check_res("R10 R8 stall", VECS[11]);
    @(negedge clk);
    chk("R10", "in_ready still stalled", 32'(in_ready), 32'd0);
    check_res("R10 R8 held", VECS[11]);
    out_ready = 1'b1;
    #1;
    chk("R10", "in_ready on release", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check_res("R10 next after stall", VECS[1]);
    @(negedge clk);
    chk("R10", "empty after drain", 32'(out_valid), 32'd0);

    // R11: reset mid-stream clears a pending result
    drive(VECS[0]);
    in_valid  = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "out_valid after mid reset", 32'(out_valid), 32'd0);
    chk("R11", "in_ready after mid reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule